// File: doc/BRIEF.md
# Per-Port Frame Arrival Timestamp Latch

This block records the moment a marker frame passes each of four ports of a chained node, so that software elsewhere can work out the propagation delay between neighbouring nodes. A register write to the port 0 receive-time slot arms a new measurement on all four ports at once. After that write, each port copies the shared nanosecond system time into its own timestamp register on the first frame-start strobe it sees, and raises its own valid flag.

Each port captures only once per arming. Any later strobe on that port leaves the stored value alone until the next arming write. The system time input carries the low 32 bits of the node's system time, and those bits are what get stored. The four stored stamps are read through a small address-selected read port. The write data of the arming access has no effect, so the block has no write data input.

Top module: `port_rx_stamper`

## Requirements
- R1: After reset, all four valid flags are 0 and every timestamp reads back as 0.
- R2: A write (`reg_wr`=1) with `reg_addr`=0 arms all ports and clears all four valid flags at the next clock edge.
- R3: After arming, the first clock edge at which a port's `frame_sof` bit is 1 stores the value `sys_time` had at that edge into that port's timestamp and sets that port's valid flag at the same edge.
- R4: Ports capture independently, and strobes arriving together on several ports are each captured with the same time value.
- R5: Once a port has captured, further strobes on it change neither its timestamp nor its valid flag until the next arming write.
- R6: A strobe present in the same cycle as the arming write is not captured for the measurement that write starts.
- R7: Strobes that arrive when no arming write has happened since reset capture nothing, and the valid flags stay 0.
- R8: Writes with `reg_addr` 1, 2 or 3 do not arm, and they change no valid flag and no timestamp.
- R9: `rd_data` shows, combinationally, the timestamp of the port selected by `rd_addr` (0 to 3).
- R10: A later arming write lets every port capture again, and the new timestamp replaces the earlier one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | 32 | Low half of the shared system time, in ns |
| frame_sof | input | 4 | One frame-start strobe per port, bit n for port n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write slot: 0 arms, 1 to 3 have no effect |
| rd_addr | input | 2 | Port whose timestamp is shown on `rd_data` |
| rd_data | output | 32 | Timestamp of the selected port |
| stamp_valid | output | 4 | Per-port flag that the timestamp holds a capture from the current arming |

## Verification
The hardest case to reach is a strobe that lands in exactly the cycle of the arming write while the flags from the previous measurement are still set. The bench gets there by issuing the arming write with every strobe raised in the same cycle. It then confirms that the flags drop and stay low, and that a later single strobe is captured. The system time is started just below a 32-bit wrap, so the stored stamps also straddle the rollover.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

    localparam int PORTS_DEF   = 4;
    localparam int STAMP_W_DEF = 32;

    // Per-port control flags held beside each stored time value
    typedef struct packed {
        logic armed;   // waiting for the first frame after arming
        logic valid;   // stamp belongs to the current measurement
    } slot_state_t;

    typedef enum logic [1:0] {
        REG_IDLE   = 2'd0,
        REG_ARM    = 2'd1,
        REG_IGNORE = 2'd2
    } reg_op_t;

    // Classify a register write; only slot 0 starts a measurement
    function automatic reg_op_t classify_write(input logic wr, input logic is_slot0);
        if (!wr)
            return REG_IDLE;
        else if (is_slot0)
            return REG_ARM;
        else
            return REG_IGNORE;
    endfunction

endpackage

// File: rtl/stamp_arm_decode.sv
module stamp_arm_decode
    import stamp_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              arm_pulse
);

    reg_op_t op;

    always_comb begin
        op        = classify_write(reg_wr, reg_addr == '0);
        arm_pulse = (op == REG_ARM);
    end

endmodule

// File: rtl/stamp_port_slot.sv
module stamp_port_slot
    import stamp_pkg::*;
#(
    parameter int STAMP_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm_pulse,
    input  logic               sof,
    input  logic [STAMP_W-1:0] now,
    output logic [STAMP_W-1:0] stamp,
    output logic               valid
);

    slot_state_t        st_q;
    logic [STAMP_W-1:0] stamp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '{armed: 1'b0, valid: 1'b0};
            stamp_q <= '0;
        end else if (arm_pulse) begin
            // a strobe in the arming cycle is dropped on purpose
            st_q <= '{armed: 1'b1, valid: 1'b0};
        end else if (st_q.armed && sof) begin
            stamp_q <= now;
            st_q    <= '{armed: 1'b0, valid: 1'b1};
        end
    end

    assign stamp = stamp_q;
    assign valid = st_q.valid;

endmodule

// File: rtl/stamp_read_mux.sv
module stamp_read_mux #(
    parameter int NPORT   = 4,
    parameter int STAMP_W = 32,
    parameter int ADDR_W  = 2
) (
    input  logic [NPORT-1:0][STAMP_W-1:0] stamps,
    input  logic [ADDR_W-1:0]             sel,
    output logic [STAMP_W-1:0]            data
);

    always_comb begin
        data = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (sel == ADDR_W'(i))
                data = stamps[i];
        end
    end

endmodule

// File: rtl/port_rx_stamper.sv
module port_rx_stamper
    import stamp_pkg::*;
#(
    parameter int NPORT   = PORTS_DEF,
    parameter int STAMP_W = STAMP_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [STAMP_W-1:0]       sys_time,
    input  logic [NPORT-1:0]         frame_sof,
    input  logic                     reg_wr,
    input  logic [$clog2(NPORT)-1:0] reg_addr,
    input  logic [$clog2(NPORT)-1:0] rd_addr,
    output logic [STAMP_W-1:0]       rd_data,
    output logic [NPORT-1:0]         stamp_valid
);

    localparam int ADDR_W = $clog2(NPORT);

    logic                            arm_pulse;
    logic [NPORT-1:0][STAMP_W-1:0]   stamp_w;

    stamp_arm_decode #(.ADDR_W(ADDR_W)) u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .arm_pulse (arm_pulse)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_slot
        stamp_port_slot #(.STAMP_W(STAMP_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .arm_pulse (arm_pulse),
            .sof       (frame_sof[p]),
            .now       (sys_time),
            .stamp     (stamp_w[p]),
            .valid     (stamp_valid[p])
        );
    end

    stamp_read_mux #(.NPORT(NPORT), .STAMP_W(STAMP_W), .ADDR_W(ADDR_W)) u_rd (
        .stamps (stamp_w),
        .sel    (rd_addr),
        .data   (rd_data)
    );

endmodule

// File: rtl/port_rx_stamper_chk.sv
module port_rx_stamper_chk #(
    parameter int NPORT   = 4,
    parameter int STAMP_W = 32
) (
    input logic                           clk,
    input logic                           rst,
    input logic [STAMP_W-1:0]             sys_time,
    input logic [NPORT-1:0]               frame_sof,
    input logic                           reg_wr,
    input logic [$clog2(NPORT)-1:0]       reg_addr,
    input logic [NPORT-1:0]               stamp_valid,
    input logic [NPORT-1:0][STAMP_W-1:0]  stamp_bus
);

    logic arm_seen;
    logic arming;
    logic other_wr;

    assign arming   = reg_wr && (reg_addr == '0);
    assign other_wr = reg_wr && (reg_addr != '0);

    always_ff @(posedge clk) begin
        if (rst)
            arm_seen <= 1'b0;
        else if (arming)
            arm_seen <= 1'b1;
    end

    a_r2_arm_clears: assert property (@(posedge clk) disable iff (rst)
        arming |=> (stamp_valid == '0));

    a_r7_idle_before_arm: assert property (@(posedge clk) disable iff (rst)
        !arm_seen |-> (stamp_valid == '0));

    a_r8_other_slot_keeps: assert property (@(posedge clk) disable iff (rst)
        other_wr |=> ((stamp_valid & $past(stamp_valid)) == $past(stamp_valid)));

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        a_r3_time_value: assert property (@(posedge clk) disable iff (rst)
            $rose(stamp_valid[p]) |-> (stamp_bus[p] == $past(sys_time)));

        a_r6_needs_strobe: assert property (@(posedge clk) disable iff (rst)
            $rose(stamp_valid[p]) |-> ($past(frame_sof[p]) && !$past(arming)));

        a_r5_no_overwrite: assert property (@(posedge clk) disable iff (rst)
            (stamp_valid[p] && !arming) |=> (stamp_valid[p] && $stable(stamp_bus[p])));
    end

endmodule

bind port_rx_stamper port_rx_stamper_chk #(.NPORT(NPORT), .STAMP_W(STAMP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sys_time    (sys_time),
    .frame_sof   (frame_sof),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .stamp_valid (stamp_valid),
    .stamp_bus   (stamp_w)
);

// File: tb/port_rx_stamper_test.sv
`timescale 1ns/1ps
module port_rx_stamper_test;

    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [63:0]   sys_full = 64'h0000_0001_FFFF_FFE8;
    logic [NP-1:0] sof   = '0;
    logic          wr    = 1'b0;
    logic [1:0]    waddr = '0;
    logic [1:0]    raddr = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] valid;

    always @(negedge clk) sys_full <= sys_full + 64'd1;

    port_rx_stamper uut (
        .clk         (clk),
        .rst         (rst),
        .sys_time    (sys_full[31:0]),
        .frame_sof   (sof),
        .reg_wr      (wr),
        .reg_addr    (waddr),
        .rd_addr     (raddr),
        .rd_data     (rdata),
        .stamp_valid (valid)
    );

    typedef struct {
        int          port;
        logic [31:0] val;
    } item_t;

    item_t       sbq[$];
    logic [31:0] held [NP];
    bit          seen [NP];
    bit          live [NP];
    int          n_chk  = 0;
    int          n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // driver: register write, optionally with strobes in the same cycle
    task automatic reg_write(input logic [1:0] a, input logic [NP-1:0] with_sof);
        @(negedge clk);
        wr = 1'b1; waddr = a; sof = with_sof;
        #1;
        if (a == 2'd0) begin
            for (int p = 0; p < NP; p++) live[p] = 1'b1;   // R6: same-cycle strobes dropped
        end else begin
            for (int p = 0; p < NP; p++)
                if (with_sof[p] && live[p]) begin
                    sbq.push_back('{p, sys_full[31:0]});
                    held[p] = sys_full[31:0];
                    live[p] = 1'b0;
                end
        end
        @(negedge clk);
        wr = 1'b0; sof = '0;
        if (a == 2'd0)
            for (int p = 0; p < NP; p++) seen[p] = 1'b0;
    endtask

    // driver: one-cycle strobe pattern
    task automatic strobe(input logic [NP-1:0] mask);
        @(negedge clk);
        sof = mask;
        #1;
        for (int p = 0; p < NP; p++)
            if (mask[p] && live[p]) begin
                sbq.push_back('{p, sys_full[31:0]});
                held[p] = sys_full[31:0];
                live[p] = 1'b0;
            end
        @(negedge clk);
        sof = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // direct read of a port, placed after the monitor's slot in the cycle
    task automatic read_port(input int p, output logic [31:0] v);
        #3.5;
        raddr = 2'(p);
        #0.2;
        v = rdata;
    endtask

    // monitor: each newly set flag pops the expected item and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                for (int p = 0; p < NP; p++) begin
                    if (valid[p] && !seen[p]) begin
                        seen[p] = 1'b1;
                        if (sbq.size() == 0) begin
                            check(1'b0, "R3 capture with none expected", 64'(p), 64'hFFFF);
                        end else begin
                            item_t it;
                            it = sbq.pop_front();
                            raddr = 2'(p);
                            #0.5;
                            check(it.port == p, "R3/R4 capture port order", 64'(p), 64'(it.port));
                            check(rdata == it.val, "R3/R9 captured time", 64'(rdata), 64'(it.val));
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        for (int p = 0; p < NP; p++) begin
            held[p] = '0; seen[p] = 1'b0; live[p] = 1'b0;
        end
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(valid == '0, "R1 valid after reset", 64'(valid), 64'd0);
        for (int p = 0; p < NP; p++) begin
            read_port(p, v);
            check(v == '0, "R1/R9 stamp after reset", 64'(v), 64'd0);
            @(negedge clk);
        end

        // R7: strobes with no arming since reset
        strobe(4'hF);
        idle(1);
        check(valid == '0, "R7 strobe before arming", 64'(valid), 64'd0);

        // R3/R4: arm, then staggered and simultaneous arrivals
        reg_write(2'd0, 4'h0);
        strobe(4'b0001);
        strobe(4'b0110);
        idle(1);
        check(valid == 4'b0111, "R4 independent flags", 64'(valid), 64'h7);
        read_port(1, v);
        check(v == held[2], "R4 simultaneous ports equal time", 64'(v), 64'(held[2]));
        @(negedge clk);
        strobe(4'b1000);
        idle(1);
        check(valid == 4'hF, "R3 all ports captured", 64'(valid), 64'hF);

        // R5: repeat strobes do not overwrite
        strobe(4'hF);
        idle(2);
        check(valid == 4'hF, "R5 flags kept", 64'(valid), 64'hF);
        for (int p = 0; p < NP; p++) begin
            read_port(p, v);
            check(v == held[p], "R5/R9 stamp kept", 64'(v), 64'(held[p]));
            @(negedge clk);
        end

        // R8: writes to other slots have no effect
        reg_write(2'd2, 4'h0);
        reg_write(2'd3, 4'h0);
        idle(1);
        check(valid == 4'hF, "R8 other slot write flags", 64'(valid), 64'hF);
        read_port(0, v);
        check(v == held[0], "R8 other slot write stamp", 64'(v), 64'(held[0]));
        @(negedge clk);

        // R2/R6: arming with strobes in the same cycle
        reg_write(2'd0, 4'hF);
        check(valid == '0, "R2 arming clears flags", 64'(valid), 64'd0);
        idle(2);
        check(valid == '0, "R6 same-cycle strobe ignored", 64'(valid), 64'd0);

        // R10: fresh capture after re-arming replaces the old value
        strobe(4'b0100);
        idle(1);
        check(valid == 4'b0100, "R10 recapture flag", 64'(valid), 64'h4);
        read_port(2, v);
        check(v == held[2], "R10 recapture value", 64'(v), 64'(held[2]));
        @(negedge clk);

        reg_write(2'd0, 4'h0);
        check(valid == '0, "R2 rearm clears partial flags", 64'(valid), 64'd0);
        idle(3);
        check(sbq.size() == 0, "R3 all expected captures seen", 64'(sbq.size()), 64'd0);

        finish_run();
    end

endmodule